// File: doc/BRIEF.md
# Jitter-Sampled Raw Bit Source

This block produces a raw random bit stream from two free-running clocks: a fast one near 1 GHz and a slow one whose period jitters. The fast clock drives a toggle flip-flop, so its state is a square wave with exactly half of each cycle high, whatever the duty cycle of the fast clock. A programmable divider slows down the sampling clock by 2^code, with the 3-bit code picking 1, 2, 4 up to 128. At each divided boundary the toggle state, brought over through a synchronizer in the slow domain, becomes one raw bit with a one-cycle valid strobe.

A larger divide code gives fewer bits per second. More jitter builds up between two samples, so the bits are less correlated. The divided boundary is also given out as a level that flips at each boundary, so the sampling rate can be watched. Entropy post-processing and bus access sit outside this block.

Top module: `jitter_bit_source`

## Requirements
- R1: While `rst_n` is low, `raw_valid`, `raw_bit` and `div_clk_o` are all 0.
- R2: The fast-domain toggle state is 0 after reset and inverts at every rising edge of `fast_clk`. With the fast clock stopped, a raw bit therefore equals the parity of the fast edges counted since reset (1 for an odd count).
- R3: The toggle state crosses into the slow domain through a synchronizer of at least two stages. A raw bit taken more than two slow cycles after the fast clock stops equals the toggle state.
- R4: In steady operation, `raw_valid` is high for single slow cycles spaced exactly 2^`div_code` slow cycles apart (code 0 gives 1, code 7 gives 128).
- R5: A change of `div_code` takes effect only at the next divided boundary. The period in progress keeps its old length and the period after it uses the new length.
- R6: `div_clk_o` inverts in exactly the slow cycles in which `raw_valid` is high, and holds its value at all other times.
- R7: `raw_bit` changes value only in a cycle in which `raw_valid` is high.
- R8: With both clocks free-running and jittered, the raw stream is balanced: each of 0 and 1 occurs in 25% to 75% of 400 consecutive bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast free-running clock that drives the toggle stage |
| slow_clk | input | 1 | Slow jittered clock that drives the divider and the sampler |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| div_code | input | 3 | Divide code; the sampling period is 2^code slow cycles |
| raw_bit | output | 1 | Most recent raw random bit |
| raw_valid | output | 1 | One-cycle strobe in the slow domain marking a new raw bit |
| div_clk_o | output | 1 | Level that flips at every divided boundary, for observation |

## Verification
The bench stops the fast clock and applies counted bursts of fast edges, so each raw bit has an exact expected parity. A sampler that skipped the toggle stage or the synchronizer would show the wrong bit. The bench changes the divide code in the middle of a period and checks the length of that period. A divider that loaded the code at once would cut the running period short, from 8 cycles to 3. The walk over codes 0 to 7 includes the 128-cycle extreme, where a counter one bit too narrow would wrap early. A free-running jittered run checks the bit balance, which catches a sampler stuck at one value. A reset issued in the middle of activity must clear every output.

// File: rtl/jbs_pkg.sv
`timescale 1ps/1ps
package jbs_pkg;

   // Number of slow cycles in one divided period, less one.
   function automatic logic [31:0] span_m1(input logic [31:0] code);
      return (32'd1 << code) - 32'd1;
   endfunction

   // Smallest counter width that holds span_m1 for the largest code.
   function automatic int unsigned cnt_width(input int unsigned code_w);
      int unsigned w;
      w = (1 << code_w) - 1;
      return (w == 0) ? 1 : w;
   endfunction

   typedef enum logic [0:0] {
      OBS_FLIP  = 1'b0,
      OBS_PULSE = 1'b1
   } obs_style_e;

endpackage

// File: rtl/jbs_toggle_stage.sv
`timescale 1ps/1ps
module jbs_toggle_stage (
   input  logic fast_clk,
   input  logic rst_n,
   output logic tgl_q
);

   // Inverting on each edge gives an exact 50% level, so the fast
   // clock's duty cycle does not reach the sampled value.
   always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= ~tgl_q;
   end

endmodule

// File: rtl/jbs_prescaler.sv
`timescale 1ps/1ps
module jbs_prescaler #(
   parameter int unsigned        CODE_W    = 3,
   parameter jbs_pkg::obs_style_e OBS_STYLE = jbs_pkg::OBS_FLIP
) (
   input  logic              slow_clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic              tick,
   output logic [CODE_W-1:0] active_code,
   output logic              obs_q
);

   localparam int unsigned CNT_W = jbs_pkg::cnt_width(CODE_W);

   if (CODE_W < 1 || CODE_W > 5) begin : g_bad_code_w
      $error("jbs_prescaler: CODE_W must lie in 1..5");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   always_comb begin
      limit = CNT_W'(jbs_pkg::span_m1(32'(active_code)));
      tick  = (cnt == limit);
   end

   // The code is loaded only at a boundary, so a running period keeps
   // the length it started with.
   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt         <= '0;
         active_code <= '0;
      end else if (tick) begin
         cnt         <= '0;
         active_code <= code_in;
      end else begin
         cnt         <= cnt + 1'b1;
      end
   end

   if (OBS_STYLE == jbs_pkg::OBS_FLIP) begin : g_obs_flip
      always_ff @(posedge slow_clk or negedge rst_n) begin
         if (!rst_n)    obs_q <= 1'b0;
         else if (tick) obs_q <= ~obs_q;
      end
   end else begin : g_obs_pulse
      always_ff @(posedge slow_clk or negedge rst_n) begin
         if (!rst_n) obs_q <= 1'b0;
         else        obs_q <= tick;
      end
   end

endmodule

// File: rtl/jbs_sync_sampler.sv
`timescale 1ps/1ps
module jbs_sync_sampler #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic slow_clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic sample_en,
   output logic bit_q,
   output logic vld_q
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("jbs_sync_sampler: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-2:0], async_in};
   end

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= sample_en;
         if (sample_en) bit_q <= chain[SYNC_STAGES-1];
      end
   end

endmodule

// File: rtl/jitter_bit_source.sv
`timescale 1ps/1ps
module jitter_bit_source #(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              fast_clk,
   input  logic              slow_clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] div_code,
   output logic              raw_bit,
   output logic              raw_valid,
   output logic              div_clk_o
);

   logic              tgl_q;
   logic              tick;
   logic [CODE_W-1:0] active_code;

   jbs_toggle_stage u_tgl (
      .fast_clk (fast_clk),
      .rst_n    (rst_n),
      .tgl_q    (tgl_q)
   );

   jbs_prescaler #(
      .CODE_W    (CODE_W),
      .OBS_STYLE (jbs_pkg::OBS_FLIP)
   ) u_div (
      .slow_clk    (slow_clk),
      .rst_n       (rst_n),
      .code_in     (div_code),
      .tick        (tick),
      .active_code (active_code),
      .obs_q       (div_clk_o)
   );

   jbs_sync_sampler #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_smp (
      .slow_clk  (slow_clk),
      .rst_n     (rst_n),
      .async_in  (tgl_q),
      .sample_en (tick),
      .bit_q     (raw_bit),
      .vld_q     (raw_valid)
   );

endmodule

// File: rtl/jbs_checker.sv
`timescale 1ps/1ps
module jbs_checker #(
   parameter int unsigned CODE_W = 3
) (
   input logic              slow_clk,
   input logic              rst_n,
   input logic              raw_bit,
   input logic              raw_valid,
   input logic              div_clk_o,
   input logic [CODE_W-1:0] active_code
);

   logic [31:0]       gap;
   logic              seen;
   logic [CODE_W-1:0] code_rec;

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         gap      <= '0;
         seen     <= 1'b0;
         code_rec <= '0;
      end else if (raw_valid) begin
         gap      <= 32'd1;
         seen     <= 1'b1;
         code_rec <= active_code;
      end else begin
         gap      <= gap + 32'd1;
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge slow_clk)
      !rst_n |-> (!raw_valid && !raw_bit && !div_clk_o));

   // R4
   period_len_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      (raw_valid && seen) |-> (gap == (32'd1 << code_rec)));

   // R5
   code_hold_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      !raw_valid |-> $stable(active_code));

   // R6
   obs_flip_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      raw_valid |-> !$stable(div_clk_o));

   // R6
   obs_hold_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      !raw_valid |-> $stable(div_clk_o));

   // R7
   bit_hold_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
      !raw_valid |-> $stable(raw_bit));

endmodule

bind jitter_bit_source jbs_checker #(.CODE_W(CODE_W)) u_chk (
   .slow_clk    (slow_clk),
   .rst_n       (rst_n),
   .raw_bit     (raw_bit),
   .raw_valid   (raw_valid),
   .div_clk_o   (div_clk_o),
   .active_code (active_code)
);

// File: tb/jitter_bit_source_tb.sv
`timescale 1ps/1ps
module jitter_bit_source_tb;

   logic       fast_clk = 1'b0;
   logic       slow_clk = 1'b0;
   logic       rst_n    = 1'b0;
   logic [2:0] div_code = 3'd0;
   logic       raw_bit, raw_valid, div_clk_o;

   int  checks = 0;
   int  fails  = 0;
   int  cyc    = 0;
   int  pend   = 0;
   int  fast_edges;
   bit  slow_jit = 1'b0;
   bit  fast_run = 1'b0;

   localparam int NV = 8;
   localparam int TBL_CODE  [NV] = '{2, 0, 1, 3, 7, 5, 4, 6};
   localparam int TBL_PULSE [NV] = '{3, 2, 5, 1, 4, 6, 7, 3};

   jitter_bit_source u_dut (
      .fast_clk  (fast_clk),
      .slow_clk  (slow_clk),
      .rst_n     (rst_n),
      .div_code  (div_code),
      .raw_bit   (raw_bit),
      .raw_valid (raw_valid),
      .div_clk_o (div_clk_o)
   );

   // 200 MHz slow clock, optionally jittered
   initial begin
      int h;
      forever begin
         h = 2500;
         if (slow_jit) h = 2100 + int'($urandom_range(800));
         #(h) slow_clk = ~slow_clk;
      end
   end

   // fast clock: free-running with jitter, or counted pulses when stopped
   initial begin
      forever begin
         if (fast_run) begin
            #(350 + int'($urandom_range(100))) fast_clk = ~fast_clk;
         end else if (fast_clk) begin
            #300 fast_clk = 1'b0;
         end else if (pend > 0) begin
            #300 fast_clk = 1'b1;
            #300 fast_clk = 1'b0;
            pend = pend - 1;
         end else begin
            #200;
         end
      end
   end

   always @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) fast_edges <= 0;
      else        fast_edges <= fast_edges + 1;
   end

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge slow_clk) begin
      cyc = cyc + 1;
      if (cyc > 150000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
         finish_up();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_fast(input int n);
      pend = n;
      wait (pend == 0);
      repeat (4) @(negedge slow_clk);
   endtask

   task automatic next_valid(output int gap, output bit held);
      logic prev;
      gap  = 0;
      held = 1'b1;
      prev = raw_bit;
      do begin
         @(negedge slow_clk);
         gap = gap + 1;
         if (!raw_valid && raw_bit !== prev) held = 1'b0;
      end while (raw_valid !== 1'b1);
   endtask

   initial begin
      int   g;
      bit   h;
      logic dv;
      int   ones;

      // R1: outputs quiet during reset
      repeat (3) @(negedge slow_clk);
      chk(raw_valid === 1'b0, "R1", "valid in reset", int'(raw_valid), 0);
      chk(raw_bit   === 1'b0, "R1", "bit in reset",   int'(raw_bit),   0);
      chk(div_clk_o === 1'b0, "R1", "div in reset",   int'(div_clk_o), 0);
      rst_n = 1'b1;

      // R2: one fast edge gives 1, a second gives 0
      pulse_fast(1);
      next_valid(g, h);
      chk(raw_bit === 1'b1, "R2", "parity after 1 edge", int'(raw_bit), 1);
      pulse_fast(1);
      next_valid(g, h);
      chk(raw_bit === 1'b0, "R2", "parity after 2 edges", int'(raw_bit), 0);

      // vector walk: divide code and burst length
      for (int i = 0; i < NV; i++) begin
         div_code = 3'(TBL_CODE[i]);
         pulse_fast(TBL_PULSE[i]);
         next_valid(g, h);
         dv = div_clk_o;
         next_valid(g, h);
         chk(g == (1 << TBL_CODE[i]), "R4", "period length", g, 1 << TBL_CODE[i]);
         chk(div_clk_o !== dv, "R6", "obs flip at boundary", int'(div_clk_o), int'(~dv));
         next_valid(g, h);
         chk(g == (1 << TBL_CODE[i]), "R4", "period length again", g, 1 << TBL_CODE[i]);
         chk(raw_bit === fast_edges[0], "R3", "synced toggle state",
             int'(raw_bit), int'(fast_edges[0]));
         chk(h, "R7", "bit held between strobes", int'(h), 1);
      end

      // R5: code change mid-period must not shorten it
      div_code = 3'd3;
      next_valid(g, h);
      next_valid(g, h);
      next_valid(g, h);
      repeat (2) @(negedge slow_clk);
      div_code = 3'd0;
      next_valid(g, h);
      chk(g + 2 == 8, "R5", "running period kept", g + 2, 8);
      next_valid(g, h);
      chk(g == 1, "R5", "new period applied", g, 1);

      // R8: free-running jittered clocks give a balanced stream
      slow_jit = 1'b1;
      fast_run = 1'b1;
      ones = 0;
      for (int k = 0; k < 400; k++) begin
         next_valid(g, h);
         if (raw_bit === 1'b1) ones = ones + 1;
      end
      chk(ones >= 100 && ones <= 300, "R8", "ones in 400 bits", ones, 200);

      // R1: reset in mid-activity clears the outputs
      fast_run = 1'b0;
      slow_jit = 1'b0;
      repeat (4) @(negedge slow_clk);
      rst_n = 1'b0;
      #1;
      chk(raw_valid === 1'b0, "R1", "valid after mid reset", int'(raw_valid), 0);
      chk(raw_bit   === 1'b0, "R1", "bit after mid reset",   int'(raw_bit),   0);
      chk(div_clk_o === 1'b0, "R1", "div after mid reset",   int'(div_clk_o), 0);
      repeat (2) @(negedge slow_clk);
      rst_n = 1'b1;
      pulse_fast(3);
      next_valid(g, h);
      chk(raw_bit === 1'b1, "R2", "parity after reset and 3 edges", int'(raw_bit), 1);

      finish_up();
   end

endmodule